// File: doc/BRIEF.md
# TLB Duplicate-Entry Scrubber

This block is the recovery sequencer that runs after a translation buffer reports that one lookup matched more than one way. A single start pulse makes it ask for the enable bit of the translation unit to be set again. It then walks every set of a set-associative TLB in ascending order. For each set it reads all ways through the TLB's read port and compares their tag words in pairs. Every redundant copy is removed through the TLB's erase port.

For each set, a local copy of the ways' tag words (PD0) is held in a small buffer. A set in which no way carries the present flag is skipped without any compare. Within a set, each way is compared with every higher-numbered way, and only the page-number part of the word is compared. When two ways match, the lower-numbered way is erased and dropped from the local copy, and the higher one is kept. A single pass therefore leaves exactly one copy of every page. Each erase can also raise a one-cycle event that names the set and the way, for a logging agent. A pulse marks the end of the pass.

The read port has a fixed latency of one cycle. Data for a request made in cycle t is valid on `rd_pd0` in cycle t+1.

Top module: `tlb_dup_scrubber`

## Requirements
- R1: Once started, the block reads every entry exactly once. It visits sets 0 to SETS-1 in order, and within each set ways 0 to WAYS-1 in order. The linear index of each read is set*WAYS+way.
- R2: If no way of a set has the present flag (PD0 bit PRESENT_BIT, default 10) set, nothing in that set is compared or erased, even when the words are identical.
- R3: Two ways match when bits PD_W-1 down to PAGE_SHIFT (default 31..13) of their PD0 words are equal. Bits below PAGE_SHIFT play no part in the match.
- R4: A way whose PD0 word is all zero is never the lower-numbered side of a compare, so it can never be erased.
- R5: When way i matches a higher way n, the block erases index set*WAYS+i, and way i takes part in no further compare. Of k matching ways, the k-1 lowest are erased and the highest is kept.
- R6: After a start is accepted, `mmu_en_req` pulses for exactly one cycle, in the cycle before the first read.
- R7: `dup_evt` pulses in the same cycle as each erase, and carries the erased way's set and way numbers, only when `verbose` is high. When `verbose` is low, erases still happen but no event is raised.
- R8: After the last set has been handled, `done` pulses for one cycle, and `busy` is low from the following cycle.
- R9: A start received while `busy` is high is ignored: the pass in progress makes no extra reads, enable requests or done pulses.
- R10: During and after reset, `busy`, `done`, `rd_req`, `er_req`, `dup_evt` and `mmu_en_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a scrub pass (pulse) |
| verbose | input | 1 | Enables duplicate events |
| mmu_en_req | output | 1 | One-cycle request to set the translation enable bit again |
| rd_req | output | 1 | TLB read request |
| rd_idx | output | $clog2(SETS*WAYS) | Linear index of the read |
| rd_pd0 | input | PD_W | Tag word returned one cycle after `rd_req` |
| er_req | output | 1 | TLB erase request |
| er_idx | output | $clog2(SETS*WAYS) | Linear index to erase |
| dup_evt | output | 1 | Duplicate-found event |
| dup_set | output | $clog2(SETS) | Set of the erased way |
| dup_way | output | $clog2(WAYS) | Way that was erased |
| done | output | 1 | Pass complete (pulse) |
| busy | output | 1 | A pass is in progress |

## Verification
Most faults in the internal state show up in the indices, ordering or counts of the read and erase requests within one pass. A set or way counter that is off by one skips or repeats an index on `rd_idx`, and the error is visible in the first set it touches. A wrong local copy or a wrong compare pointer shows up when the pass ends: a copy is erased when it should be kept, or a duplicate is left in place, or the erase index is wrong. A broken sequencing state shows up as a missing or extra `done` pulse, or as `busy` staying high, and the bench's timeout exposes it within one pass.

// File: rtl/tlb_scrub_pkg.sv
// Package: shared types for the duplicate-entry scrubber.
// Assumes: nothing beyond the standard language.
package tlb_scrub_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,    // waiting for start
        ST_EN,      // request the translation enable bit
        ST_READ,    // issue one read per way
        ST_SETTLE,  // last read data lands in the buffer
        ST_CHECK,   // decide whether the set holds anything valid
        ST_CMP,     // one pair compare per cycle
        ST_DONE     // completion pulse
    } scrub_state_e;

endpackage

// File: rtl/tlb_scrub_waybuf.sv
// Module: local copy of the PD0 words of one set.
// Captures one word per cycle, zeroes a way on request, offers two words
// through read selectors, and reports whether any way has its present flag.
// Assumes: a capture and a clear never target the same cycle.
module tlb_scrub_waybuf #(
    parameter int WAYS        = 4,
    parameter int PD_W        = 32,
    parameter int PRESENT_BIT = 10,
    localparam int WW         = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [WW-1:0]   wr_way,
    input  logic [PD_W-1:0] wr_data,
    input  logic            clr_en,
    input  logic [WW-1:0]   clr_way,
    input  logic [WW-1:0]   sel_a,
    input  logic [WW-1:0]   sel_b,
    output logic [PD_W-1:0] word_a,
    output logic [PD_W-1:0] word_b,
    output logic            any_present
);

    logic [PD_W-1:0] word_q [WAYS];
    logic [WAYS-1:0] pres;

    // Store captured words and zero the copy of an erased way.
    always_ff @(posedge clk) begin
        for (int w = 0; w < WAYS; w++) begin
            if (!rst_n) begin
                word_q[w] <= '0;
            end else if (wr_en && (int'(wr_way) == w)) begin
                word_q[w] <= wr_data;
            end else if (clr_en && (int'(clr_way) == w)) begin
                word_q[w] <= '0;
            end
        end
    end

    // Gather the present flag of each way.
    for (genvar g = 0; g < WAYS; g++) begin : g_pres
        assign pres[g] = word_q[g][PRESENT_BIT];
    end

    assign any_present = |pres;
    assign word_a      = word_q[sel_a];
    assign word_b      = word_q[sel_b];

    // R5: an erased way's local copy is empty in the next cycle.
    a_r5_copy_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> (word_q[$past(clr_way)] == '0));

endmodule

// File: rtl/tlb_scrub_cmp.sv
// Module: pair comparator on the page-number part of two PD0 words.
// A zero left word never matches.
// Assumes: PAGE_SHIFT < PD_W.
module tlb_scrub_cmp #(
    parameter int PD_W       = 32,
    parameter int PAGE_SHIFT = 13
) (
    input  logic [PD_W-1:0] left_pd0,
    input  logic [PD_W-1:0] right_pd0,
    output logic            hit
);

    logic [PD_W-1:0] page_mask;

    // Build the page mask: ones from PAGE_SHIFT upward.
    for (genvar b = 0; b < PD_W; b++) begin : g_mask
        assign page_mask[b] = (b >= PAGE_SHIFT);
    end

    // Decide whether the two words name the same page.
    always_comb begin
        hit = (left_pd0 != '0) && ((left_pd0 & page_mask) == (right_pd0 & page_mask));
    end

endmodule

// File: rtl/tlb_dup_scrubber.sv
// Module: top of the duplicate-entry scrubber.
// Walks all sets, reads each way through a one-cycle-latency read port,
// compares ways in pairs and erases the lower-numbered copy of each match.
// Assumes: 2 <= WAYS <= 4; the read port returns data one cycle after rd_req;
// the erase port acts on the edge at which er_req is high.
module tlb_dup_scrubber
    import tlb_scrub_pkg::*;
#(
    parameter int SETS        = 8,
    parameter int WAYS        = 4,
    parameter int PD_W        = 32,
    parameter int PAGE_SHIFT  = 13,
    parameter int PRESENT_BIT = 10,
    localparam int SW         = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WW         = $clog2(WAYS),
    localparam int IW         = $clog2(SETS * WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            verbose,
    output logic            mmu_en_req,
    output logic            rd_req,
    output logic [IW-1:0]   rd_idx,
    input  logic [PD_W-1:0] rd_pd0,
    output logic            er_req,
    output logic [IW-1:0]   er_idx,
    output logic            dup_evt,
    output logic [SW-1:0]   dup_set,
    output logic [WW-1:0]   dup_way,
    output logic            done,
    output logic            busy
);

    scrub_state_e    state_q, state_d;
    logic [SW-1:0]   set_q, set_d;
    logic [WW-1:0]   rway_q, rway_d;
    logic [WW-1:0]   li_q, li_d;
    logic [WW-1:0]   rn_q, rn_d;
    logic            cap_vld_q;
    logic [WW-1:0]   cap_way_q;
    logic [PD_W-1:0] left_w, right_w;
    logic            any_present;
    logic            hit;
    logic            last_set;

    assign last_set = (set_q == SW'(SETS - 1));

    // Next-state logic for the set/way walk and the pair compare.
    always_comb begin
        state_d = state_q;
        set_d   = set_q;
        rway_d  = rway_q;
        li_d    = li_q;
        rn_d    = rn_q;
        case (state_q)
            ST_IDLE:   if (start) state_d = ST_EN;
            ST_EN: begin
                state_d = ST_READ;
                set_d   = '0;
                rway_d  = '0;
            end
            ST_READ: begin
                if (rway_q == WW'(WAYS - 1)) state_d = ST_SETTLE;
                else                         rway_d  = rway_q + 1'b1;
            end
            ST_SETTLE: state_d = ST_CHECK;
            ST_CHECK: begin
                if (any_present) begin
                    state_d = ST_CMP;
                    li_d    = '0;
                    rn_d    = WW'(1);
                end else if (last_set) begin
                    state_d = ST_DONE;
                end else begin
                    state_d = ST_READ;
                    set_d   = set_q + 1'b1;
                    rway_d  = '0;
                end
            end
            ST_CMP: begin
                if (hit || (rn_q == WW'(WAYS - 1))) begin
                    if (li_q == WW'(WAYS - 2)) begin
                        if (last_set) begin
                            state_d = ST_DONE;
                        end else begin
                            state_d = ST_READ;
                            set_d   = set_q + 1'b1;
                            rway_d  = '0;
                        end
                    end else begin
                        li_d = li_q + 1'b1;
                        rn_d = li_q + WW'(2);
                    end
                end else begin
                    rn_d = rn_q + 1'b1;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            set_q   <= '0;
            rway_q  <= '0;
            li_q    <= '0;
            rn_q    <= '0;
        end else begin
            state_q <= state_d;
            set_q   <= set_d;
            rway_q  <= rway_d;
            li_q    <= li_d;
            rn_q    <= rn_d;
        end
    end

    // Track which way the returning read data belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_vld_q <= 1'b0;
            cap_way_q <= '0;
        end else begin
            cap_vld_q <= rd_req;
            cap_way_q <= rway_q;
        end
    end

    tlb_scrub_waybuf #(
        .WAYS        (WAYS),
        .PD_W        (PD_W),
        .PRESENT_BIT (PRESENT_BIT)
    ) u_waybuf (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cap_vld_q),
        .wr_way      (cap_way_q),
        .wr_data     (rd_pd0),
        .clr_en      (er_req),
        .clr_way     (li_q),
        .sel_a       (li_q),
        .sel_b       (rn_q),
        .word_a      (left_w),
        .word_b      (right_w),
        .any_present (any_present)
    );

    tlb_scrub_cmp #(
        .PD_W       (PD_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_cmp (
        .left_pd0  (left_w),
        .right_pd0 (right_w),
        .hit       (hit)
    );

    // Port outputs decoded from the walk state.
    assign mmu_en_req = (state_q == ST_EN);
    assign rd_req     = (state_q == ST_READ);
    assign rd_idx     = IW'(set_q) * IW'(WAYS) + IW'(rway_q);
    assign er_req     = (state_q == ST_CMP) && hit;
    assign er_idx     = IW'(set_q) * IW'(WAYS) + IW'(li_q);
    assign dup_evt    = er_req && verbose;
    assign dup_set    = set_q;
    assign dup_way    = li_q;
    assign done       = (state_q == ST_DONE);
    assign busy       = (state_q != ST_IDLE);

    // R6: the enable request is followed directly by the read of index 0.
    a_r6_enable_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        mmu_en_req |=> (rd_req && (rd_idx == '0)));

    // R1: every read index lies inside the TLB.
    a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (int'(rd_idx) < SETS * WAYS));

    // R5: erases never overlap a read of the same set.
    a_r5_erase_not_reading: assert property (@(posedge clk) disable iff (!rst_n)
        er_req |-> !rd_req);

    // R7: an event always accompanies an erase and needs verbose.
    a_r7_event_with_erase: assert property (@(posedge clk) disable iff (!rst_n)
        dup_evt |-> (er_req && verbose && (er_idx == IW'(dup_set) * IW'(WAYS) + IW'(dup_way))));

    // R8: done is a single pulse and the block is idle right after it.
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R9: a running pass stays busy until its done pulse, whatever start does.
    a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: tb/tlb_dup_scrubber_tb.sv
`timescale 1ns/1ps
// Directed bench for the duplicate-entry scrubber with a behavioural TLB.
module tlb_dup_scrubber_tb;

    localparam int SETS  = 8;
    localparam int WAYS  = 4;
    localparam int PD_W  = 32;
    localparam int IW    = $clog2(SETS * WAYS);
    localparam int SW    = $clog2(SETS);
    localparam int WW    = $clog2(WAYS);
    localparam int N     = SETS * WAYS;
    localparam logic [31:0] PRES = 32'h0000_0400;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            verbose = 1'b1;
    logic            mmu_en_req, rd_req, er_req, dup_evt, done, busy;
    logic [IW-1:0]   rd_idx, er_idx;
    logic [PD_W-1:0] rd_pd0 = '0;
    logic [SW-1:0]   dup_set;
    logic [WW-1:0]   dup_way;

    logic [31:0] mem [N];

    int checks = 0;
    int errors = 0;
    int n_rd, n_er, n_evt, n_done, n_en, order_bad, en_late;
    int er_log [16];
    int ev_set [16];
    int ev_way [16];

    always #10 clk = ~clk;

    tlb_dup_scrubber #(.SETS(SETS), .WAYS(WAYS), .PD_W(PD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .verbose(verbose),
        .mmu_en_req(mmu_en_req), .rd_req(rd_req), .rd_idx(rd_idx),
        .rd_pd0(rd_pd0), .er_req(er_req), .er_idx(er_idx),
        .dup_evt(dup_evt), .dup_set(dup_set), .dup_way(dup_way),
        .done(done), .busy(busy)
    );

    // Behavioural TLB: one-cycle read latency, erase on the edge.
    always @(posedge clk) begin
        if (rd_req) rd_pd0 <= mem[rd_idx];
        if (er_req) mem[er_idx] <= '0;
    end

    // Port monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mmu_en_req) n_en++;
            if (rd_req) begin
                if (n_en == 0) en_late++;
                if (int'(rd_idx) != n_rd) order_bad++;
                n_rd++;
            end
            if (er_req) begin
                if (n_er < 16) er_log[n_er] = int'(er_idx);
                n_er++;
            end
            if (dup_evt) begin
                if (n_evt < 16) begin
                    ev_set[n_evt] = int'(dup_set);
                    ev_way[n_evt] = int'(dup_way);
                end
                n_evt++;
            end
            if (done) n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < N; i++) mem[i] = '0;
    endtask

    function automatic logic [31:0] pg(input int page, input bit p, input int low);
        return (32'(page) << 13) | (p ? PRES : 32'h0) | 32'(low & 8'hFF);
    endfunction

    // Run one pass; optionally pulse start again while busy.
    task automatic run_scan(input bit verb, input bit extra_start);
        int t;
        n_rd = 0; n_er = 0; n_evt = 0; n_done = 0; n_en = 0;
        order_bad = 0; en_late = 0;
        verbose = verb;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (extra_start) begin
            repeat (8) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (n_done == 0 && t < 2000) begin
            @(negedge clk);
            t++;
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !rd_req && !er_req && !dup_evt && !mmu_en_req, "R10 reset outputs",
            {busy, done, rd_req, er_req, dup_evt, mmu_en_req}, 0);
    endtask

    task automatic t_empty();
        clear_mem();
        run_scan(1'b1, 1'b0);
        chk(n_rd == N, "R1 read count", n_rd, N);
        chk(order_bad == 0, "R1 read order", order_bad, 0);
        chk(n_en == 1, "R6 enable pulses", n_en, 1);
        chk(en_late == 0, "R6 enable before first read", en_late, 0);
        chk(n_er == 0, "R2 empty TLB erases", n_er, 0);
        chk(n_done == 1, "R8 done pulses", n_done, 1);
        chk(!busy, "R8 idle after done", busy, 0);
    endtask

    task automatic load_pair();
        clear_mem();
        mem[8]  = pg(7, 1, 5);
        mem[9]  = pg(5, 1, 5);
        mem[10] = pg(9, 1, 5);
        mem[11] = pg(5, 1, 3);
    endtask

    task automatic t_pair();
        load_pair();
        run_scan(1'b1, 1'b0);
        chk(n_er == 1, "R3 low bits ignored, one erase", n_er, 1);
        chk(er_log[0] == 9, "R5 erase lower way index", er_log[0], 9);
        chk(mem[9] == 0, "R5 erased entry", int'(mem[9]), 0);
        chk(mem[11] == pg(5, 1, 3), "R5 later way kept", int'(mem[11]), int'(pg(5, 1, 3)));
        chk(n_evt == 1 && ev_set[0] == 2 && ev_way[0] == 1, "R7 event set/way",
            ev_set[0] * 10 + ev_way[0], 21);
    endtask

    task automatic t_triple();
        clear_mem();
        mem[20] = pg(3, 1, 1);
        mem[21] = pg(3, 1, 2);
        mem[22] = pg(3, 1, 4);
        mem[23] = pg(4, 1, 1);
        run_scan(1'b1, 1'b0);
        chk(n_er == 2, "R5 triple erase count", n_er, 2);
        chk(er_log[0] == 20 && er_log[1] == 21, "R5 triple erase order",
            er_log[0] * 100 + er_log[1], 2021);
        chk(mem[22] == pg(3, 1, 4), "R5 highest copy kept", int'(mem[22]), int'(pg(3, 1, 4)));
        chk(mem[23] == pg(4, 1, 1), "R3 other page untouched", int'(mem[23]), int'(pg(4, 1, 1)));
    endtask

    task automatic t_upper();
        clear_mem();
        mem[4] = pg(2, 1, 0);
        mem[6] = pg(2, 1, 0) | 32'h8000_0000;
        run_scan(1'b1, 1'b0);
        chk(n_er == 0, "R3 top bit differs, no erase", n_er, 0);
    endtask

    task automatic t_nopresent();
        clear_mem();
        mem[12] = pg(6, 0, 7);
        mem[13] = pg(6, 0, 7);
        run_scan(1'b1, 1'b0);
        chk(n_er == 0, "R2 set without present skipped", n_er, 0);
        chk(mem[12] == pg(6, 0, 7), "R2 entry kept", int'(mem[12]), int'(pg(6, 0, 7)));
    endtask

    task automatic t_zero_left();
        clear_mem();
        mem[16] = 32'h0;
        mem[17] = pg(1, 1, 0);
        mem[18] = pg(2, 1, 0);
        mem[19] = PRES;
        run_scan(1'b1, 1'b0);
        chk(n_er == 0, "R4 zero word not left side", n_er, 0);
        chk(mem[19] == PRES, "R4 page-zero entry kept", int'(mem[19]), int'(PRES));
    endtask

    task automatic t_quiet();
        load_pair();
        run_scan(1'b0, 1'b0);
        chk(n_er == 1, "R7 erase without verbose", n_er, 1);
        chk(n_evt == 0, "R7 no event without verbose", n_evt, 0);
    endtask

    task automatic t_busy_start();
        load_pair();
        run_scan(1'b1, 1'b1);
        chk(n_done == 1, "R9 single done", n_done, 1);
        chk(n_en == 1, "R9 single enable", n_en, 1);
        chk(n_rd == N, "R9 no extra reads", n_rd, N);
        chk(!busy, "R9 idle afterwards", busy, 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_pair();
        t_triple();
        t_upper();
        t_nopresent();
        t_zero_left();
        t_quiet();
        t_busy_start();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule